// File: doc/BRIEF.md
# UART Transmitter with Deferred Divisor Update

This block turns bytes written by a host into an asynchronous serial stream. Each write strobe offers one byte. In queued mode the bytes wait in a 16-entry queue. With queued mode off, only a single holding word is available. A character is sent as follows: a low start bit, the eight data bits with the least significant bit first, an optional even or odd parity bit, and a high stop bit. The line rests high between characters.

The bit rate comes from a 16x oversampling tick. A whole-cycle divisor and a 6-bit fractional divisor, counted in 64ths, set the tick spacing. The block captures both divisors and the parity settings when a character starts. Later changes to those inputs therefore have no effect until the next character. The host watches the full flag to avoid lost bytes, the empty flag to refill the queue, and the busy flag to learn when the line has drained.

Top module: `uart_tx_dd`

## Requirements
- R1: After reset, txd is 1, busy is 0, empty is 1 and full is 0.
- R2: With fifo_en=1 the block holds up to 16 waiting bytes and sends them in write order. Full is 1 exactly when 16 bytes are waiting.
- R3: With fifo_en=0 the waiting capacity is one byte, and full is 1 whenever a byte is waiting. The character being shifted out does not count as waiting.
- R4: A write is dropped when full is 1 in the cycle of the write strobe, even if a byte leaves the queue in that same cycle.
- R5: When the line is idle and a byte is waiting, the byte is taken on the next clock edge and txd goes low from that edge. The frame is: start bit 0, then data bits 0 to 7, then parity if par_en=1, then stop bit 1. Each bit lasts 16 ticks. The line is 1 between characters, and a following character may start one cycle after the stop bit ends.
- R6: The parity bit is the XOR of the 8 data bits when par_odd=0 (even parity), and its inverse when par_odd=1 (odd parity).
- R7: Tick timing within a character works as follows. The accumulator starts at 0, and the first tick period is div_int cycles. At each tick, div_frac is added to a 6-bit accumulator. A tick whose addition reaches 64 or more makes the next period div_int+1 cycles; otherwise the next period is div_int cycles.
- R8: div_int, div_frac, par_en and par_odd are sampled when a character starts. Changes made during that character affect only later characters.
- R9: busy is 1 while a character is being shifted out or any byte is waiting. Empty is 1 exactly when no byte is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to send |
| fifo_en | input | 1 | 1: 16-entry queue, 0: single holding word |
| par_en | input | 1 | Insert a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| div_int | input | 16 | Whole-cycle tick divisor, at least 1 |
| div_frac | input | 6 | Fractional tick divisor in 64ths |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Character in flight or bytes waiting |
| full | output | 1 | No room for another byte |
| empty | output | 1 | No byte waiting |

## Verification
The bench fills the queue past its depth while a character is being shifted out. A design that let a write through when full, or that counted the slot freed in that same cycle, would emit an extra byte. Holding-word mode is driven with back-to-back writes, so a design that kept the deep queue would send bytes that should have been dropped. Divisors and parity are changed in the middle of a character: a design that applied them at once would shift that character's bit edges or its parity bit. A fractional divisor exercises the 64ths carry, where an off-by-one period would show up as drift in the bit edges.

// File: rtl/uart_tx_dd.sv
module uart_tx_dd #(
  parameter int DEPTH  = 16,
  parameter int IDIV_W = 16,
  parameter int FDIV_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              fifo_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [IDIV_W-1:0] div_int,
  input  logic [FDIV_W-1:0] div_frac,
  output logic              txd,
  output logic              busy,
  output logic              full,
  output logic              empty
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]        mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [AW:0]       cnt_q;
  logic              active;
  logic [9:0]        shreg;
  logic [3:0]        bleft, sub;
  logic [IDIV_W:0]   cnt_b;
  logic              ext;
  logic [FDIV_W-1:0] facc;
  logic [IDIV_W-1:0] lat_int;
  logic [FDIV_W-1:0] lat_frac;

  wire [AW:0]     cap  = fifo_en ? (AW+1)'(DEPTH) : (AW+1)'(1);
  wire            push = wr_en & ~full;
  wire            load = ~active & ~empty;
  wire [7:0]      head = mem[rp];
  wire            pbit = (^head) ^ par_odd;
  wire [IDIV_W:0] per  = {1'b0, lat_int} + {{IDIV_W{1'b0}}, ext};
  wire            tick = active && (cnt_b == per - 1'b1);
  wire [FDIV_W:0] fsum = {1'b0, facc} + {1'b0, lat_frac};

  assign full  = cnt_q >= cap;
  assign empty = cnt_q == '0;
  assign busy  = active | ~empty;

  always_ff @(posedge clk)
    if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (load) rp <= rp + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push) - (AW+1)'(load);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active   <= 1'b0;
      txd      <= 1'b1;
      shreg    <= '1;
      bleft    <= '0;
      sub      <= '0;
      cnt_b    <= '0;
      ext      <= 1'b0;
      facc     <= '0;
      lat_int  <= '0;
      lat_frac <= '0;
    end else if (load) begin
      active   <= 1'b1;
      txd      <= 1'b0;
      shreg    <= par_en ? {1'b1, pbit, head} : {2'b11, head};
      bleft    <= par_en ? 4'd10 : 4'd9;
      sub      <= '0;
      cnt_b    <= '0;
      ext      <= 1'b0;
      facc     <= '0;
      lat_int  <= div_int;
      lat_frac <= div_frac;
    end else if (tick) begin
      cnt_b <= '0;
      {ext, facc} <= fsum;
      sub <= sub + 1'b1;
      if (sub == 4'd15) begin
        if (bleft == '0) begin
          active <= 1'b0;
          txd    <= 1'b1;
        end else begin
          txd   <= shreg[0];
          shreg <= {1'b1, shreg[9:1]};
          bleft <= bleft - 1'b1;
        end
      end
    end else if (active) begin
      cnt_b <= cnt_b + 1'b1;
    end
endmodule

// File: rtl/uart_tx_dd_chk.sv
module uart_tx_dd_chk #(
  parameter int AW     = 4,
  parameter int IDIV_W = 16,
  parameter int FDIV_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              fifo_en,
  input logic              txd,
  input logic              busy,
  input logic              full,
  input logic              empty,
  input logic              active,
  input logic [AW:0]       cnt_q,
  input logic [IDIV_W-1:0] lat_int,
  input logic [FDIV_W-1:0] lat_frac
);
  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> txd);
  // R2
  full_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n) full |-> !empty);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en) |=> (cnt_q <= $past(cnt_q)));
  // R3
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && empty && wr_en) |=> (full || fifo_en));
  // R5
  start_in_char_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(txd) |-> active);
  // R8
  divisor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ($stable(lat_int) && $stable(lat_frac)));
  // R9
  busy_from_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !empty);
endmodule

bind uart_tx_dd uart_tx_dd_chk #(.AW(AW), .IDIV_W(IDIV_W), .FDIV_W(FDIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fifo_en(fifo_en), .txd(txd),
  .busy(busy), .full(full), .empty(empty), .active(active), .cnt_q(cnt_q),
  .lat_int(lat_int), .lat_frac(lat_frac)
);

// File: tb/uart_tx_dd_tb.sv
`timescale 1ns/100ps
module uart_tx_dd_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, fifo_en = 1, par_en = 0, par_odd = 0;
  logic [7:0] wr_data = 0;
  logic [15:0] div_int = 2;
  logic [5:0] div_frac = 0;
  logic txd, busy, full, empty;

  uart_tx_dd u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_en(fifo_en), .par_en(par_en), .par_odd(par_odd), .div_int(div_int),
    .div_frac(div_frac), .txd(txd), .busy(busy), .full(full), .empty(empty));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  byte unsigned q[$];
  bit m_act = 0, m_txd = 1;
  int m_bits[11];
  int m_nb, m_idx, m_sub, m_cnt, m_ext, m_facc, m_int, m_frac;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_act = 0; m_txd = 1;
    end else begin
      int cap, sz;
      bit ld, pu;
      cap = fifo_en ? 16 : 1;
      sz = q.size();
      ld = !m_act && sz > 0;
      pu = wr_en && sz < cap;
      if (ld) begin
        byte unsigned b;
        int p;
        b = q.pop_front();
        p = par_odd;
        m_bits[0] = 0;
        for (int i = 0; i < 8; i++) begin
          m_bits[i+1] = (b >> i) & 1;
          p ^= m_bits[i+1];
        end
        if (par_en) begin m_bits[9] = p; m_bits[10] = 1; m_nb = 11; end
        else begin m_bits[9] = 1; m_nb = 10; end
        m_act = 1; m_txd = 0; m_idx = 0; m_sub = 0; m_cnt = 0;
        m_ext = 0; m_facc = 0; m_int = div_int; m_frac = div_frac;
      end else if (m_act) begin
        if (m_cnt == m_int + m_ext - 1) begin
          m_cnt = 0;
          m_facc += m_frac;
          m_ext = (m_facc >= 64);
          m_facc %= 64;
          if (m_sub == 15) begin
            m_sub = 0;
            m_idx++;
            if (m_idx == m_nb) begin m_act = 0; m_txd = 1; end
            else m_txd = m_bits[m_idx][0];
          end else m_sub++;
        end else m_cnt++;
      end
      if (pu) q.push_back(wr_data);
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("txd", txd, m_txd);
    chk("busy", busy, m_act || q.size() > 0);
    chk("empty", empty, q.size() == 0);
    chk("full", full, q.size() >= (fifo_en ? 16 : 1));
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put(byte unsigned b);
    wr_en = 1; wr_data = b;
    step(1);
    wr_en = 0;
  endtask

  task automatic drain();
    while (busy) step(1);
    step(3);
  endtask

  initial begin
    step(2);
    // R1: reset state
    chk("reset txd", txd, 1);
    chk("reset busy", busy, 0);
    chk("reset empty", empty, 1);
    chk("reset full", full, 0);
    rst_n = 1;
    step(1);

    // R2/R5/R9: queued bytes, no parity
    tag = "R2/R5/R9";
    put(8'hA5); put(8'h3C); put(8'h01);
    drain();

    // R6/R7: parity and fractional divisor
    tag = "R6/R7";
    div_int = 1; div_frac = 6'd40; par_en = 1; par_odd = 0;
    put(8'h96); put(8'h7F);
    drain();
    par_odd = 1; div_frac = 6'd63;
    put(8'h96); put(8'h00);
    drain();

    // R4/R2: overfill while a character is in flight
    tag = "R4/R2";
    div_int = 1; div_frac = 0; par_en = 0;
    for (int i = 0; i < 20; i++) put(8'(i * 13 + 1));
    drain();

    // R3/R4: single holding word
    tag = "R3/R4";
    fifo_en = 0;
    put(8'h11); put(8'h22); put(8'h33);
    step(5);
    put(8'h44);
    drain();

    // R8: settings changed mid-character
    tag = "R8";
    fifo_en = 1; div_int = 2; div_frac = 0; par_en = 0;
    put(8'hC3); put(8'h5A);
    step(60);
    div_int = 3; div_frac = 6'd10; par_en = 1; par_odd = 1;
    drain();

    finish_run();
  end
endmodule